// File: doc/BRIEF.md
# Frame Trigger and Test-Injection Sequencer

This block sets the frame timing for a pixel detector test chip and drives the digital side of its in-pixel test charge injection. An external trigger starts frames. In single mode each rising trigger edge runs exactly one frame. In continuous mode frames run back to back until software writes a stop request. Each frame lasts a programmable number of clock cycles. The default is 311 cycles, which gives a frame rate near 534 kHz at a 166 MHz clock. The block marks the first cycle of each frame with `frame_start` and the last cycle with `frame_end`.

Inside a frame, an injection slot opens every `interval` cycles, and the first slot falls on the frame's first cycle. A 16-bit rotating pattern decides which slots fire. A slot that fires raises `inject_en` for a programmable number of cycles and presents the programmed amplitude code on `inject_amp`. The analog current sources that use these outputs are outside the block.

Configuration goes through a small write-only register port. Period, pattern, amplitude, interval and pulse width are held in staging registers. They are copied into the working set only at a frame boundary, so a frame that is already running never changes shape.

The controller has two states. `SEQ_IDLE` waits for a trigger edge. `SEQ_RUN` counts the frame. It has three transitions:
- start: `SEQ_IDLE`→`SEQ_RUN`, taken on a synchronised trigger rising edge.
- repeat: `SEQ_RUN`→`SEQ_RUN`, taken at frame end when continuous mode is set and no stop is pending.
- finish: `SEQ_RUN`→`SEQ_IDLE`, taken at frame end in every other case.

Top module: `inj_frame_sequencer`

## Requirements
- R1: After reset, `frame_start`, `frame_end`, `frame_active` and `inject_en` are 0 and `inject_amp` is 0. The staging defaults are: period 311, pattern 0x0001, amplitude 0, interval 16, width 2, single mode.
- R2: In `SEQ_IDLE`, a rising edge on `trig_in` starts a frame. `frame_start` is high for exactly the first cycle of the frame and `frame_active` is high for the whole frame. Holding `trig_in` high starts no further frames.
- R3: A frame lasts exactly `period` cycles, with `frame_end` high on its last cycle. A period value below 2 is treated as 2.
- R4: In single mode (control bit 0 = 0), the block returns to `SEQ_IDLE` after one frame. Trigger edges that arrive while a frame is running are ignored.
- R5: In continuous mode (control bit 0 = 1), the next `frame_start` comes in the cycle right after `frame_end`. Writing control with bit 1 = 1 lets the current frame finish and then returns to `SEQ_IDLE`.
- R6: Injection slots fall at frame offsets 0, I, 2I, and so on, where I is the interval; an interval of 0 is treated as 1. Slot k fires if bit (k mod 16) of the pattern is 1, with bit 0 used first. A slot at offset s that fires drives `inject_en` high from offset s+1 for `width` cycles. If a later firing slot arrives during the pulse, the pulse restarts. Pulses are cut off at the end of the frame.
- R7: `inject_amp` equals the amplitude code while `inject_en` is high and is 0 otherwise.
- R8: Writes to period, pattern, amplitude, interval and width take effect at the next frame start and leave the running frame unchanged. The register addresses are: 0 period, 1 pattern, 2 amplitude (bits 7:0), 3 interval, 4 width, 5 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Asynchronous external frame trigger |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| frame_start | output | 1 | High on the first cycle of a frame |
| frame_end | output | 1 | High on the last cycle of a frame |
| frame_active | output | 1 | High while a frame is running |
| inject_en | output | 1 | Test-injection enable |
| inject_amp | output | 8 | Injection amplitude code, 0 when idle |

## Verification
The bench sweeps injection patterns chosen to hit the injector's edge cases:
- An interval of 2 with 17 slots, which forces the pattern to wrap. A design that indexed the pattern without wrapping would fire the wrong slot.
- A width larger than the interval, which makes pulses overlap. A design that dropped the restart would leave gaps.
- A last slot on the final frame cycle, which checks that the pulse is cut off at the frame end.
- A zero interval, which a design lacking the clamp would never leave.

Further tests aim at the frame controller:
- A second trigger edge during a single frame. A design that did not ignore it would run a second frame.
- A trigger held high. A design that was level-sensitive would repeat frames.
- A period write in the middle of a continuous run. A design that applied it at once would shorten the current frame.
- A stop request. A design that acted on it immediately would cut the frame short, and one that lost it would never return to idle.

// File: rtl/injseq_pkg.sv
`timescale 1ns/1ps
package injseq_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_PATTERN  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_AMP      = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_INTERVAL = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_WIDTH    = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd5;
endpackage

// File: rtl/injseq_trig_sync.sv
`timescale 1ns/1ps
module injseq_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o
);
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-1:0], trig_i};
    end

    assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/injseq_regs.sv
`timescale 1ns/1ps
module injseq_regs
    import injseq_pkg::*;
#(
    parameter int DW           = 16,
    parameter int PAT_W        = 16,
    parameter int AMP_W        = 8,
    parameter int DEF_PERIOD   = 311,
    parameter int DEF_INTERVAL = 16,
    parameter int DEF_WIDTH    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic              load_i,
    output logic [DW-1:0]     period_o,
    output logic [PAT_W-1:0]  pat_next_o,
    output logic [DW-1:0]     interval_o,
    output logic [DW-1:0]     width_o,
    output logic [AMP_W-1:0]  amp_o,
    output logic              cont_o,
    output logic              stop_wr_o
);
    localparam logic [DW-1:0] MIN_PERIOD   = DW'(2);
    localparam logic [DW-1:0] MIN_INTERVAL = DW'(1);

    logic [DW-1:0]    stg_period, stg_interval, stg_width;
    logic [PAT_W-1:0] stg_pat;
    logic [AMP_W-1:0] stg_amp;
    logic [DW-1:0]    act_period, act_interval, act_width;
    logic [AMP_W-1:0] act_amp;
    logic             cont_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_period   <= DW'(DEF_PERIOD);
            stg_pat      <= PAT_W'(1);
            stg_amp      <= '0;
            stg_interval <= DW'(DEF_INTERVAL);
            stg_width    <= DW'(DEF_WIDTH);
            cont_q       <= 1'b0;
        end else if (we_i) begin
            unique case (addr_i)
                ADDR_PERIOD:   stg_period   <= wdata_i;
                ADDR_PATTERN:  stg_pat      <= wdata_i[PAT_W-1:0];
                ADDR_AMP:      stg_amp      <= wdata_i[AMP_W-1:0];
                ADDR_INTERVAL: stg_interval <= wdata_i;
                ADDR_WIDTH:    stg_width    <= wdata_i;
                ADDR_CTRL:     cont_q       <= wdata_i[0];
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_period   <= DW'(DEF_PERIOD);
            act_amp      <= '0;
            act_interval <= DW'(DEF_INTERVAL);
            act_width    <= DW'(DEF_WIDTH);
        end else if (load_i) begin
            act_period   <= stg_period;
            act_amp      <= stg_amp;
            act_interval <= stg_interval;
            act_width    <= stg_width;
        end
    end

    assign period_o   = (act_period < MIN_PERIOD) ? MIN_PERIOD : act_period;
    assign interval_o = (act_interval < MIN_INTERVAL) ? MIN_INTERVAL : act_interval;
    assign width_o    = act_width;
    assign amp_o      = act_amp;
    assign pat_next_o = stg_pat;
    assign cont_o     = cont_q;
    assign stop_wr_o  = we_i && (addr_i == ADDR_CTRL) && wdata_i[1];
endmodule

// File: rtl/injseq_ctrl.sv
`timescale 1ns/1ps
module injseq_ctrl
    import injseq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_rise_i,
    input  logic [DW-1:0] period_i,
    input  logic          cont_i,
    input  logic          stop_wr_i,
    output logic          frame_start_o,
    output logic          frame_end_o,
    output logic          active_o,
    output logic          load_o
);
    seq_state_t    state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic          stop_q;
    logic          last_cycle, keep_going;

    assign last_cycle = (cnt_q == period_i - DW'(1));
    assign keep_going = cont_i && !stop_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (trig_rise_i) state_d = SEQ_RUN;
            SEQ_RUN:  if (last_cycle && !keep_going) state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (state_q != SEQ_RUN || load_o) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  stop_q <= 1'b0;
        else if (state_q == SEQ_IDLE) stop_q <= 1'b0;
        else if (stop_wr_i)          stop_q <= 1'b1;
    end

    always_comb begin
        frame_start_o = 1'b0;
        frame_end_o   = 1'b0;
        active_o      = 1'b0;
        load_o        = 1'b0;
        unique case (state_q)
            SEQ_IDLE: load_o = trig_rise_i;
            SEQ_RUN: begin
                active_o      = 1'b1;
                frame_start_o = (cnt_q == '0);
                frame_end_o   = last_cycle;
                load_o        = last_cycle && keep_going;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/injseq_pulse_gen.sv
`timescale 1ns/1ps
module injseq_pulse_gen #(
    parameter int DW    = 16,
    parameter int PAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PAT_W-1:0] pat_i,
    input  logic [DW-1:0]    interval_i,
    input  logic [DW-1:0]    width_i,
    output logic             inject_en_o
);
    logic [PAT_W-1:0] shreg_q;
    logic [DW-1:0]    slot_cnt_q, width_cnt_q;
    logic             slot_now;

    assign slot_now = (slot_cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            slot_cnt_q  <= '0;
            width_cnt_q <= '0;
        end else if (restart_i) begin
            shreg_q     <= pat_i;
            slot_cnt_q  <= '0;
            width_cnt_q <= '0;
        end else if (!run_i) begin
            slot_cnt_q  <= '0;
            width_cnt_q <= '0;
        end else begin
            if (slot_now) begin
                shreg_q <= {shreg_q[0], shreg_q[PAT_W-1:1]};
                if (shreg_q[0])              width_cnt_q <= width_i;
                else if (width_cnt_q != '0)  width_cnt_q <= width_cnt_q - DW'(1);
            end else if (width_cnt_q != '0) begin
                width_cnt_q <= width_cnt_q - DW'(1);
            end
            slot_cnt_q <= (slot_cnt_q >= interval_i - DW'(1)) ? '0 : slot_cnt_q + DW'(1);
        end
    end

    assign inject_en_o = (width_cnt_q != '0);
endmodule

// File: rtl/inj_frame_sequencer.sv
`timescale 1ns/1ps
module inj_frame_sequencer
    import injseq_pkg::*;
#(
    parameter int DW         = 16,
    parameter int PAT_W      = 16,
    parameter int AMP_W      = 8,
    parameter int DEF_PERIOD = 311,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic              frame_start,
    output logic              frame_end,
    output logic              frame_active,
    output logic              inject_en,
    output logic [AMP_W-1:0]  inject_amp
);
    logic             trig_rise, load, stop_wr, cont;
    logic [DW-1:0]    period, interval, width;
    logic [PAT_W-1:0] pat_next;
    logic [AMP_W-1:0] amp;

    injseq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_in), .rise_o(trig_rise)
    );

    injseq_regs #(.DW(DW), .PAT_W(PAT_W), .AMP_W(AMP_W), .DEF_PERIOD(DEF_PERIOD)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
        .load_i(load), .period_o(period), .pat_next_o(pat_next), .interval_o(interval),
        .width_o(width), .amp_o(amp), .cont_o(cont), .stop_wr_o(stop_wr)
    );

    injseq_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_rise_i(trig_rise), .period_i(period),
        .cont_i(cont), .stop_wr_i(stop_wr), .frame_start_o(frame_start),
        .frame_end_o(frame_end), .active_o(frame_active), .load_o(load)
    );

    injseq_pulse_gen #(.DW(DW), .PAT_W(PAT_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .run_i(frame_active), .restart_i(load | frame_end),
        .pat_i(pat_next), .interval_i(interval), .width_i(width), .inject_en_o(inject_en)
    );

    assign inject_amp = inject_en ? amp : '0;
endmodule

// File: rtl/injseq_checker.sv
`timescale 1ns/1ps
module injseq_checker #(
    parameter int AMP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             frame_end,
    input logic             frame_active,
    input logic             inject_en,
    input logic [AMP_W-1:0] inject_amp
);
    assert_start_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> frame_active);

    assert_min_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_end_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> frame_active);

    assert_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (!frame_active || frame_start));

    assert_inject_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inject_en |-> frame_active);

    assert_amp_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !inject_en |-> (inject_amp == '0));
endmodule

bind inj_frame_sequencer injseq_checker #(.AMP_W(AMP_W)) u_injseq_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .frame_active(frame_active), .inject_en(inject_en), .inject_amp(inject_amp)
);

// File: tb/inj_frame_sequencer_bench.sv
`timescale 1ns/1ps
module inj_frame_sequencer_bench;
    localparam int CLK_PERIOD = 6;
    localparam int NVEC = 5;

    typedef struct packed {
        logic [15:0] period;
        logic [15:0] pattern;
        logic [15:0] interval;
        logic [15:0] width;
        logic [15:0] amp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{16'd60, 16'h0001, 16'd10, 16'd3, 16'h005A},
        '{16'd50, 16'h0006, 16'd7,  16'd2, 16'h0011},
        '{16'd45, 16'hFFFF, 16'd4,  16'd6, 16'h00FF},
        '{16'd33, 16'h8001, 16'd2,  16'd1, 16'h0003},
        '{16'd20, 16'h0003, 16'd0,  16'd1, 16'h0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        frame_start, frame_end, frame_active, inject_en;
    logic [7:0]  inject_amp;

    int checks = 0;
    int errors = 0;
    int run_len = 0;
    int last_len = 0;
    int n_ends = 0;
    int n_starts = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inj_frame_sequencer u_inj_frame_sequencer (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .frame_start(frame_start),
        .frame_end(frame_end), .frame_active(frame_active),
        .inject_en(inject_en), .inject_amp(inject_amp)
    );

    always @(negedge clk) begin
        cycles++;
        if (frame_start) begin run_len = 1; n_starts++; end
        else if (frame_active) run_len++;
        if (frame_end) begin last_len = run_len; n_ends++; end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig_in = 1'b1;
        repeat (2) @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic wait_start(output bit found);
        found = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (frame_start) begin found = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (!frame_active) break;
            @(negedge clk);
        end
    endtask

    function automatic bit exp_en(input int t, input int p, input logic [15:0] pat,
                                  input int ival, input int w);
        bit r = 1'b0;
        for (int s = 0; s < t; s += ival) begin
            if (pat[(s / ival) % 16] && (t - s) >= 1 && (t - s) <= w) r = 1'b1;
        end
        return r && (t < p);
    endfunction

    initial begin
        bit found;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!frame_start && !frame_end && !frame_active, "R1 frame flags at reset",
              {frame_start, frame_end, frame_active}, 0);
        check(!inject_en && inject_amp == 0, "R1 injection at reset", int'(inject_amp), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 default period 311
        pulse_trig();
        wait_start(found);
        check(found, "R2 trigger starts frame", int'(found), 1);
        wait_idle();
        check(last_len == 311, "R1 default period", last_len, 311);

        // Vector table: R3 R6 R7 R4
        for (int v = 0; v < NVEC; v++) begin
            int p, ival, w, en_err, amp_err, end_err;
            p    = int'(VECS[v].period);
            ival = (VECS[v].interval == 0) ? 1 : int'(VECS[v].interval);
            w    = int'(VECS[v].width);
            en_err = 0; amp_err = 0; end_err = 0;
            write_reg(3'd0, VECS[v].period);
            write_reg(3'd1, VECS[v].pattern);
            write_reg(3'd2, VECS[v].amp);
            write_reg(3'd3, VECS[v].interval);
            write_reg(3'd4, VECS[v].width);
            pulse_trig();
            wait_start(found);
            check(found, "R2 vector frame start", int'(found), 1);
            for (int t = 0; t < p; t++) begin
                bit e;
                e = exp_en(t, p, VECS[v].pattern, ival, w);
                if (inject_en !== e) begin
                    en_err++;
                    $display("  vec %0d offset %0d inject_en %0b exp %0b", v, t, inject_en, e);
                end
                if (inject_amp !== (e ? VECS[v].amp[7:0] : 8'h00)) amp_err++;
                if (frame_end !== (t == p - 1) || frame_active !== 1'b1) end_err++;
                @(negedge clk);
            end
            check(en_err == 0, "R6 injection pattern", en_err, 0);
            check(amp_err == 0, "R7 amplitude code", amp_err, 0);
            check(end_err == 0 && last_len == p, "R3 frame length", last_len, p);
            check(!frame_active && !inject_en, "R4 single frame returns idle",
                  int'(frame_active), 0);
        end

        // R4: retrigger during a single frame is ignored
        write_reg(3'd0, 16'd60);
        pulse_trig();
        wait_start(found);
        repeat (10) @(negedge clk);
        begin
            int s0;
            s0 = n_starts;
            pulse_trig();
            wait_idle();
            repeat (40) @(negedge clk);
            check(n_starts == s0 && !frame_active, "R4 retrigger ignored", n_starts - s0, 0);
        end

        // R2: held trigger gives one frame
        write_reg(3'd0, 16'd30);
        begin
            int s0;
            s0 = n_starts;
            @(negedge clk);
            trig_in = 1'b1;
            repeat (200) @(negedge clk);
            check(n_starts == s0 + 1, "R2 level trigger one frame", n_starts - s0, 1);
            trig_in = 1'b0;
            repeat (5) @(negedge clk);
        end

        // R3: period below 2 clamps to 2
        write_reg(3'd0, 16'd1);
        pulse_trig();
        wait_start(found);
        wait_idle();
        check(last_len == 2, "R3 period clamp", last_len, 2);

        // R5 and R8: continuous run, period change mid frame, stop
        write_reg(3'd0, 16'd40);
        write_reg(3'd5, 16'h0001);
        pulse_trig();
        wait_start(found);
        repeat (5) @(negedge clk);
        write_reg(3'd0, 16'd25);
        begin
            int e0;
            e0 = n_ends;
            while (n_ends == e0) @(negedge clk);
            check(last_len == 40, "R8 running frame keeps period", last_len, 40);
            check(frame_start === 1'b1, "R5 back to back start", int'(frame_start), 1);
            while (n_ends == e0 + 1) @(negedge clk);
            check(last_len == 25, "R8 new period at boundary", last_len, 25);
            repeat (3) @(negedge clk);
            write_reg(3'd5, 16'h0003);
            check(frame_active === 1'b1, "R5 stop waits for frame end", int'(frame_active), 1);
            wait_idle();
            check(last_len == 25, "R5 stopped frame full length", last_len, 25);
            repeat (40) @(negedge clk);
            check(!frame_active, "R5 idle after stop", int'(frame_active), 0);
        end
        write_reg(3'd5, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule